// File: doc/BRIEF.md
# Lazy floating-point fault escalation unit

This block decides the fate of a fault that is raised while the processor is lazily saving its floating-point registers. At that moment the live exception state no longer describes the context that owns the floating-point data, so the decision is made from readiness flags captured in a context control word when stacking began. There is a secure copy and a non-secure copy of that word. From the request the block determines four things. It decides whether the fault is taken as requested, is promoted to a hard fault, or is dropped. It also picks the vector bank, reports whether the fault can pre-empt or the core must lock up, and states whether a pending bit must be set.

A request is a one-cycle strobe carrying an exception number, a bank select and the context words, along with the vector data and the current execution priority. The result appears one clock later as a one-cycle strobe together with its fields. Neither side can apply back-pressure. The caller must take each result in the cycle it is presented, and it may issue a new request in every cycle. A separate combinational query port reports whether a given exception is ready. Ready means it is enabled and its priority would let it pre-empt the current execution priority.

Exception numbers: hard fault 3, memory-management fault 4, bus fault 5, usage fault 6, security fault 7, debug monitor 12. Priorities are signed 9-bit group priorities, so that -1 and -3 can be expressed. Context word bit positions: 0 hard-fault ready, 1 memory-management ready, 2 usage ready, 3 bus ready, 4 security ready, 5 monitor ready.

Top module: `lfp_escalate_top`

## Requirements
- R1: After reset, res_valid, res_lockup, res_forced, res_pend_set, res_drop and res_err are all 0.
- R2: res_valid is 1 exactly in the cycle after a cycle with req_valid at 1, and all result fields belong to that request.
- R3: A debug monitor request (12) with bit 5 of the secure context word clear is dropped: res_drop=1, res_exc=12, and res_lockup, res_forced and res_pend_set are all 0.
- R4: A memory-management (4) or usage (6) fault escalates when bit 1 (respectively bit 2) is clear in the context word of the selected bank (secure when req_sec=1, else non-secure).
- R5: A bus (5) or security (7) fault escalates when bit 3 (respectively bit 4) of the secure context word is clear, whatever the non-secure word holds.
- R6: An escalated request reports res_exc=3 and res_forced=1. A request that is not escalated reports its own number and res_forced=0.
- R7: An escalated request uses the secure bank (res_bank_s=1) only when sec_ext=1 and either the original fault targeted secure state or hf_to_ns=0. Targeting secure state means a banked fault with req_sec=1, a bus fault with hf_to_ns=0, or any security fault.
- R8: A request that is not escalated reports res_bank_s=1 only for a banked fault (4 or 6) requested with req_sec=1.
- R9: res_lockup=1 when bit 0 of the secure context word is clear and the chosen vector is either disabled or has a priority not strictly below exec_prio. A hard-fault vector counts as enabled, with priority hf_prio_s or hf_prio_ns depending on its bank.
- R10: res_pend_set=1 only when the chosen vector's pending input is 0. That input is vec_pend, hf_pend_s or hf_pend_ns.
- R11: A request for an unsupported number, or one with req_sec=1 for a non-banked fault, gives res_err=1 and leaves res_lockup, res_forced, res_pend_set and res_drop at 0.
- R12: qry_ready for number 3 is 1 exactly when exec_prio > -1, whatever qry_en holds. For other numbers it is 1 exactly when qry_en=1 and qry_prio < exec_prio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_exc | input | 9 | Requested exception number |
| req_sec | input | 1 | Bank select for banked faults |
| ctx_s | input | 6 | Secure copy of the saved context word |
| ctx_ns | input | 6 | Non-secure copy of the saved context word |
| sec_ext | input | 1 | Security extension present |
| hf_to_ns | input | 1 | Hard and bus faults routed to non-secure state |
| vec_en | input | 1 | Enable of the requested vector |
| vec_prio | input | 9 | Group priority of the requested vector (signed) |
| vec_pend | input | 1 | Pending bit of the requested vector |
| hf_prio_s | input | 9 | Secure hard-fault priority (signed) |
| hf_prio_ns | input | 9 | Non-secure hard-fault priority (signed) |
| hf_pend_s | input | 1 | Secure hard-fault pending bit |
| hf_pend_ns | input | 1 | Non-secure hard-fault pending bit |
| exec_prio | input | 9 | Current execution priority (signed) |
| qry_exc | input | 9 | Exception number for the ready query |
| qry_en | input | 1 | Enable of the queried vector |
| qry_prio | input | 9 | Group priority of the queried vector (signed) |
| qry_ready | output | 1 | Queried exception is ready |
| res_valid | output | 1 | Result strobe |
| res_exc | output | 9 | Exception to pend |
| res_bank_s | output | 1 | Use the secure vector bank |
| res_lockup | output | 1 | Fault cannot pre-empt; lockup |
| res_forced | output | 1 | Set strobe for the forced hard-fault status bit |
| res_pend_set | output | 1 | Set the pending bit and recompute priorities |
| res_drop | output | 1 | Request silently dropped |
| res_err | output | 1 | Malformed request, ignored |

## Verification
Escalation and lockup can occur in the same result. This happens when a fault is promoted to a secure hard fault whose priority is -3 while the execution priority is also -3 and the hard-fault ready bit is clear. The bench applies exactly that vector. It expects res_exc=3, res_forced=1, res_bank_s=1 and res_lockup=1 together, with res_pend_set still reflecting the secure hard-fault pending input. Separate rows show each condition alone, so that a design which lets one suppress or imply the other would fail.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  localparam int EXC_NUM_W = 9;
  localparam int PRIO_NUM_W = 9;

  localparam int EXC_HARD = 3;
  localparam int EXC_MEM  = 4;
  localparam int EXC_BUS  = 5;
  localparam int EXC_USE  = 6;
  localparam int EXC_SEC  = 7;
  localparam int EXC_MON  = 12;

  // Saved readiness flags, bit 5 down to bit 0
  typedef struct packed {
    logic mon;
    logic sf;
    logic bf;
    logic uf;
    logic mm;
    logic hf;
  } ctx_t;

  localparam int CTX_W = $bits(ctx_t);
endpackage

// File: rtl/lfp_classify.sv
module lfp_classify #(
  parameter int EW = 9
) (
  input  logic [EW-1:0]   exc,
  input  logic            sec,
  input  lfp_pkg::ctx_t   cs,
  input  lfp_pkg::ctx_t   cn,
  input  logic            sec_ext,
  input  logic            hf_to_ns,
  output logic            banked,
  output logic            err,
  output logic            drop,
  output logic            esc,
  output logic            tgt_s
);
  import lfp_pkg::*;

  localparam logic [EW-1:0] E_MEM = EW'(EXC_MEM);
  localparam logic [EW-1:0] E_BUS = EW'(EXC_BUS);
  localparam logic [EW-1:0] E_USE = EW'(EXC_USE);
  localparam logic [EW-1:0] E_SEC = EW'(EXC_SEC);
  localparam logic [EW-1:0] E_MON = EW'(EXC_MON);

  ctx_t sel_ctx;
  logic known, esc_raw, drop_raw;
  logic ctx_unused;

  assign ctx_unused = ^{cn.hf, cn.bf, cn.sf, cn.mon, cs.hf};

  assign banked  = (exc == E_MEM) || (exc == E_USE);
  assign known   = banked || (exc == E_BUS) || (exc == E_SEC) || (exc == E_MON);
  assign err     = !known || (sec && !banked);
  assign sel_ctx = (banked && sec) ? cs : cn;

  always_comb begin
    esc_raw  = 1'b0;
    drop_raw = 1'b0;
    unique case (exc)
      E_MEM:   esc_raw  = !sel_ctx.mm;
      E_USE:   esc_raw  = !sel_ctx.uf;
      E_BUS:   esc_raw  = !cs.bf;
      E_SEC:   esc_raw  = !cs.sf;
      E_MON:   drop_raw = !cs.mon;
      default: ;
    endcase
  end

  assign esc  = esc_raw && !err;
  assign drop = drop_raw && !err;

  always_comb begin
    if (banked)              tgt_s = sec;
    else if (exc == E_BUS)   tgt_s = sec_ext && !hf_to_ns;
    else if (exc == E_SEC)   tgt_s = sec_ext;
    else                     tgt_s = 1'b0;
  end
endmodule

// File: rtl/lfp_target.sv
module lfp_target #(
  parameter int EW = 9,
  parameter int PW = 9
) (
  input  logic [EW-1:0]        exc,
  input  logic                 sec,
  input  logic                 banked,
  input  logic                 esc,
  input  logic                 tgt_s,
  input  logic                 sec_ext,
  input  logic                 hf_to_ns,
  input  logic                 hf_rdy,
  input  logic                 vec_en,
  input  logic signed [PW-1:0] vec_prio,
  input  logic                 vec_pend,
  input  logic signed [PW-1:0] hf_prio_s,
  input  logic signed [PW-1:0] hf_prio_ns,
  input  logic                 hf_pend_s,
  input  logic                 hf_pend_ns,
  input  logic signed [PW-1:0] exec_prio,
  output logic [EW-1:0]        out_exc,
  output logic                 bank_s,
  output logic                 lockup,
  output logic                 pend_set
);
  localparam logic [EW-1:0] E_HARD = EW'(lfp_pkg::EXC_HARD);

  logic                 ch_en, ch_pend;
  logic signed [PW-1:0] ch_prio;

  always_comb begin
    if (esc) begin
      out_exc = E_HARD;
      bank_s  = sec_ext && (tgt_s || !hf_to_ns);
      ch_en   = 1'b1;
      ch_prio = bank_s ? hf_prio_s : hf_prio_ns;
      ch_pend = bank_s ? hf_pend_s : hf_pend_ns;
    end else begin
      out_exc = exc;
      bank_s  = banked && sec;
      ch_en   = vec_en;
      ch_prio = vec_prio;
      ch_pend = vec_pend;
    end
  end

  assign lockup   = (!ch_en || !(ch_prio < exec_prio)) && !hf_rdy;
  assign pend_set = !ch_pend;
endmodule

// File: rtl/lfp_ready_query.sv
module lfp_ready_query #(
  parameter int EW = 9,
  parameter int PW = 9
) (
  input  logic [EW-1:0]        exc,
  input  logic                 en,
  input  logic signed [PW-1:0] prio,
  input  logic signed [PW-1:0] exec_prio,
  output logic                 ready
);
  localparam logic [EW-1:0]        E_HARD = EW'(lfp_pkg::EXC_HARD);
  localparam logic signed [PW-1:0] MINUS1 = '1;

  assign ready = (exc == E_HARD) ? (exec_prio > MINUS1) : (en && (prio < exec_prio));
endmodule

// File: rtl/lfp_escalate_top.sv
module lfp_escalate_top #(
  parameter int EXC_W  = lfp_pkg::EXC_NUM_W,
  parameter int PRIO_W = lfp_pkg::PRIO_NUM_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [EXC_W-1:0]         req_exc,
  input  logic                     req_sec,
  input  logic [lfp_pkg::CTX_W-1:0] ctx_s,
  input  logic [lfp_pkg::CTX_W-1:0] ctx_ns,
  input  logic                     sec_ext,
  input  logic                     hf_to_ns,
  input  logic                     vec_en,
  input  logic signed [PRIO_W-1:0] vec_prio,
  input  logic                     vec_pend,
  input  logic signed [PRIO_W-1:0] hf_prio_s,
  input  logic signed [PRIO_W-1:0] hf_prio_ns,
  input  logic                     hf_pend_s,
  input  logic                     hf_pend_ns,
  input  logic signed [PRIO_W-1:0] exec_prio,
  input  logic [EXC_W-1:0]         qry_exc,
  input  logic                     qry_en,
  input  logic signed [PRIO_W-1:0] qry_prio,
  output logic                     qry_ready,
  output logic                     res_valid,
  output logic [EXC_W-1:0]         res_exc,
  output logic                     res_bank_s,
  output logic                     res_lockup,
  output logic                     res_forced,
  output logic                     res_pend_set,
  output logic                     res_drop,
  output logic                     res_err
);
  import lfp_pkg::*;

  localparam logic [EXC_W-1:0] E_HARD = EXC_W'(EXC_HARD);
  localparam logic [EXC_W-1:0] E_MON  = EXC_W'(EXC_MON);

  ctx_t             cs_w, cn_w;
  logic             banked, err, drop, esc, tgt_s;
  logic [EXC_W-1:0] t_exc;
  logic             t_bank, t_lock, t_pend, act;

  assign cs_w = ctx_t'(ctx_s);
  assign cn_w = ctx_t'(ctx_ns);

  lfp_classify #(.EW(EXC_W)) u_cls (
    .exc(req_exc), .sec(req_sec), .cs(cs_w), .cn(cn_w),
    .sec_ext(sec_ext), .hf_to_ns(hf_to_ns),
    .banked(banked), .err(err), .drop(drop), .esc(esc), .tgt_s(tgt_s)
  );

  lfp_target #(.EW(EXC_W), .PW(PRIO_W)) u_tgt (
    .exc(req_exc), .sec(req_sec), .banked(banked), .esc(esc), .tgt_s(tgt_s),
    .sec_ext(sec_ext), .hf_to_ns(hf_to_ns), .hf_rdy(cs_w.hf),
    .vec_en(vec_en), .vec_prio(vec_prio), .vec_pend(vec_pend),
    .hf_prio_s(hf_prio_s), .hf_prio_ns(hf_prio_ns),
    .hf_pend_s(hf_pend_s), .hf_pend_ns(hf_pend_ns),
    .exec_prio(exec_prio),
    .out_exc(t_exc), .bank_s(t_bank), .lockup(t_lock), .pend_set(t_pend)
  );

  lfp_ready_query #(.EW(EXC_W), .PW(PRIO_W)) u_qry (
    .exc(qry_exc), .en(qry_en), .prio(qry_prio), .exec_prio(exec_prio),
    .ready(qry_ready)
  );

  assign act = req_valid && !err && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_exc      <= '0;
      res_bank_s   <= 1'b0;
      res_lockup   <= 1'b0;
      res_forced   <= 1'b0;
      res_pend_set <= 1'b0;
      res_drop     <= 1'b0;
      res_err      <= 1'b0;
    end else begin
      res_valid    <= req_valid;
      res_lockup   <= act && t_lock;
      res_forced   <= act && esc;
      res_pend_set <= act && t_pend;
      res_drop     <= req_valid && drop;
      res_err      <= req_valid && err;
      if (req_valid) begin
        res_exc    <= t_exc;
        res_bank_s <= t_bank;
      end
    end
  end

  // R2
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(req_valid));

  // R3
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_drop |-> (res_exc == E_MON) && !res_pend_set && !res_forced && !res_lockup);

  // R6
  forced_is_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_forced |-> res_valid && (res_exc == E_HARD));

  // R7
  no_sec_bank_without_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_forced && !$past(sec_ext)) |-> !res_bank_s);

  // R11
  err_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> !res_lockup && !res_forced && !res_pend_set && !res_drop);

  // R10
  pend_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_pend_set |-> res_valid);
endmodule

// File: tb/lfp_escalate_top_tb_top.sv
module lfp_escalate_top_tb_top;
  typedef struct packed {
    logic [8:0] exc;  logic sel; logic [5:0] cs; logic [5:0] cn;
    logic sx; logic hn; logic en; logic [8:0] pr; logic [8:0] ep;
    logic vp; logic hps; logic hpn;
    logic [8:0] xexc; logic xb; logic xl; logic xf; logic xp; logic xd; logic xe;
  } tv_t;

  localparam int NV = 18;
  localparam tv_t TV [NV] = '{
    // R4 memory fault, ready, no escalation
    '{9'd4, 1'b0, 6'h3F, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    // R4 secure bank memory fault not ready -> secure hard fault
    '{9'd4, 1'b1, 6'h3D, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    // R4 R7 non-secure memory fault -> non-secure hard fault, already pending
    '{9'd4, 1'b0, 6'h3F, 6'h3D, 1'b1, 1'b1, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b1, 9'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    // R4 usage fault, no security extension
    '{9'd6, 1'b0, 6'h3F, 6'h3B, 1'b0, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    // R4 R8 secure usage fault reads secure word only
    '{9'd6, 1'b1, 6'h3F, 6'h3B, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    // R5 R7 bus fault not ready, routed secure
    '{9'd5, 1'b0, 6'h37, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    // R5 bus fault: non-secure word ignored
    '{9'd5, 1'b0, 6'h3F, 6'h37, 1'b1, 1'b1, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    // R5 R7 security fault -> secure hard fault, already pending
    '{9'd7, 1'b0, 6'h2F, 6'h3F, 1'b1, 1'b1, 1'b1, 9'd5, 9'd16, 1'b0, 1'b1, 1'b0, 9'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    // R3 monitor dropped
    '{9'd12, 1'b0, 6'h1F, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    // R3 monitor ready -> pended normally
    '{9'd12, 1'b0, 6'h3F, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    // R9 equal priority with hard-fault ready clear -> lockup
    '{9'd4, 1'b0, 6'h3E, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd16, 9'd16, 1'b0, 1'b0, 1'b0, 9'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    // R9 disabled vector -> lockup
    '{9'd6, 1'b0, 6'h3E, 6'h3F, 1'b1, 1'b0, 1'b0, 9'd0, 9'd16, 1'b0, 1'b0, 1'b0, 9'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    // R9 disabled vector but hard-fault ready set -> no lockup
    '{9'd6, 1'b0, 6'h3F, 6'h3F, 1'b1, 1'b0, 1'b0, 9'd0, 9'd16, 1'b0, 1'b0, 1'b0, 9'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    // R6 R9 escalation and lockup together
    '{9'd5, 1'b0, 6'h36, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, -9'sd3, 1'b0, 1'b0, 1'b0, 9'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    // R11 secure select on non-banked bus fault
    '{9'd5, 1'b1, 6'h30, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    // R11 unsupported number
    '{9'd9, 1'b0, 6'h00, 6'h00, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    // R11 secure select on monitor
    '{9'd12, 1'b1, 6'h1F, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b0, 1'b0, 1'b0, 9'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    // R10 vector already pending
    '{9'd4, 1'b0, 6'h3F, 6'h3F, 1'b1, 1'b0, 1'b1, 9'd5, 9'd16, 1'b1, 1'b0, 1'b0, 9'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_sec = 1'b0;
  logic [8:0] req_exc = '0;
  logic [5:0] ctx_s = '0, ctx_ns = '0;
  logic sec_ext = 1'b0, hf_to_ns = 1'b0, vec_en = 1'b0, vec_pend = 1'b0;
  logic signed [8:0] vec_prio = '0, exec_prio = '0, qry_prio = '0;
  logic signed [8:0] hf_prio_s = -9'sd3, hf_prio_ns = -9'sd1;
  logic hf_pend_s = 1'b0, hf_pend_ns = 1'b0;
  logic [8:0] qry_exc = '0;
  logic qry_en = 1'b0;
  logic qry_ready, res_valid, res_bank_s, res_lockup, res_forced, res_pend_set, res_drop, res_err;
  logic [8:0] res_exc;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lfp_escalate_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_exc(req_exc), .req_sec(req_sec),
    .ctx_s(ctx_s), .ctx_ns(ctx_ns), .sec_ext(sec_ext), .hf_to_ns(hf_to_ns),
    .vec_en(vec_en), .vec_prio(vec_prio), .vec_pend(vec_pend),
    .hf_prio_s(hf_prio_s), .hf_prio_ns(hf_prio_ns), .hf_pend_s(hf_pend_s), .hf_pend_ns(hf_pend_ns),
    .exec_prio(exec_prio), .qry_exc(qry_exc), .qry_en(qry_en), .qry_prio(qry_prio),
    .qry_ready(qry_ready), .res_valid(res_valid), .res_exc(res_exc), .res_bank_s(res_bank_s),
    .res_lockup(res_lockup), .res_forced(res_forced), .res_pend_set(res_pend_set),
    .res_drop(res_drop), .res_err(res_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(int i);
    tv_t v;
    v = TV[i];
    @(negedge clk);
    req_exc = v.exc; req_sec = v.sel; ctx_s = v.cs; ctx_ns = v.cn;
    sec_ext = v.sx; hf_to_ns = v.hn; vec_en = v.en; vec_prio = v.pr;
    exec_prio = v.ep; vec_pend = v.vp; hf_pend_s = v.hps; hf_pend_ns = v.hpn;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    $display("row %0d", i);
    chk("R2 valid", res_valid, 1);
    chk("R6 exc", res_exc, v.xexc);
    chk("R7 R8 bank", res_bank_s, v.xb);
    chk("R9 lockup", res_lockup, v.xl);
    chk("R6 forced", res_forced, v.xf);
    chk("R10 pend", res_pend_set, v.xp);
    chk("R3 drop", res_drop, v.xd);
    chk("R11 err", res_err, v.xe);
  endtask

  task automatic query(int e, bit en, int pr, int ep, bit exp, string tag);
    @(negedge clk);
    qry_exc = 9'(e); qry_en = en; qry_prio = 9'(pr); exec_prio = 9'(ep);
    #1;
    chk(tag, qry_ready, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", res_valid, 0);
    chk("R1 lockup", res_lockup, 0);
    chk("R1 forced", res_forced, 0);
    chk("R1 pend", res_pend_set | res_drop | res_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid idle", res_valid, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2 strobe lasts one cycle only
    @(negedge clk);
    chk("R2 single pulse", res_valid, 0);
    chk("R2 no stray pend", res_pend_set, 0);

    // R12 ready query
    query(3, 1'b0, 0, 0, 1'b1, "R12 hard ready at 0");
    query(3, 1'b1, 0, -1, 1'b0, "R12 hard not ready at -1");
    query(4, 1'b1, 2, 3, 1'b1, "R12 below exec");
    query(4, 1'b1, 3, 3, 1'b0, "R12 equal exec");
    query(6, 1'b0, 0, 3, 1'b0, "R12 disabled");
    query(5, 1'b1, -2, -1, 1'b1, "R12 negative prio");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule